// File: doc/BRIEF.md
# Disconnect Termination Controller for a Slow Bus Target

This block sequences the target-side control strobes of a shared parallel bus transaction for a slow device. It claims the access after a decode hit, offers data phases, and ends the burst by a disconnect when the device asks for one. The request to stop is shown together with the target-ready strobe for exactly one data phase. The target-ready strobe is then dropped, while stop and device-select stay asserted for as long as the master keeps its cycle-frame signal asserted, whatever the number of master wait states.

The controller reacts to the master releasing the frame within one clock. It then drives all three strobes to their inactive level for one clock with the output enable still high, and returns to idle. The rest of the slow device may take longer to respond. This block exists so that this one edge is never late and the strobes are never released early.

The strobes are modelled as plain active-low signals with a separate enable. A pulse output marks every data phase that moves a word, so that a surrounding design or a bench can count transfers.

Top module: `disc_ctrl`

## Requirements
- R1: While rst_ni is low, and in idle, devsel_no, trdy_no and stop_no are 1 and oe_o and xfer_o are 0.
- R2: A clock edge in idle with frame_ni=0 and hit_i=1 starts a claim. devsel_no and oe_o go active in the next cycle. trdy_no goes to 0 exactly CLAIM_CYC cycles later (default 1).
- R3: While trdy_no=0, xfer_o is 1 in exactly the cycles where irdy_ni=0. trdy_no stays 0 across cycles with irdy_ni=1.
- R4: stop_req_i=1, sampled during the claim or a data phase, makes stop_no=0 from the next data-phase cycle on, with trdy_no still 0. This is a disconnect with data.
- R5: After a data phase completes with stop_no=0, trdy_no=0, irdy_ni=0 and frame_ni=0, trdy_no goes to 1. stop_no and devsel_no stay 0 for every cycle in which frame_ni was sampled 0, including master wait states with irdy_ni=1.
- R6: frame_ni sampled 1 while stop is held makes devsel_no, trdy_no and stop_no all 1 in the next cycle, with oe_o=1 for that single cycle. The controller is idle with oe_o=0 one cycle after that.
- R7: A data phase that completes (irdy_ni=0, trdy_no=0) with frame_ni=1 ends the access. The strobes are released the next cycle, with the same one-cycle release as in R6.
- R8: A disconnect shown on a data phase that completes with frame_ni=1 goes straight to release, without a hold phase.
- R9: Once stop is being held, devsel_no and stop_no are never 1 in a cycle where frame_ni is 0.
- R10: In idle, hit_i=0 or frame_ni=1 leaves all strobes inactive and starts no claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_ni | input | 1 | Master cycle-frame, active low |
| irdy_ni | input | 1 | Master ready, active low |
| hit_i | input | 1 | Address decode hit for the current access |
| stop_req_i | input | 1 | Device request to disconnect, active high |
| devsel_no | output | 1 | Device select, active low |
| trdy_no | output | 1 | Target ready, active low |
| stop_no | output | 1 | Target stop, active low |
| oe_o | output | 1 | Enable for the three strobes |
| xfer_o | output | 1 | One-cycle pulse per data phase that moves a word |

## Verification
The strobes are decoded from registered state. An input sampled at edge k therefore shows up on the strobes in the cycle that follows edge k, and only the claim delay adds CLAIM_CYC cycles before target-ready. xfer_o is combinational from irdy_ni in the same cycle. The bench drives inputs on the falling edge, compares all five outputs one time unit later against a cycle model advanced at each rising edge, and so checks every result in the cycle it is due. Hold lengths of 0, 1 and 5 master wait states are run as directed cases, then a long random master run is added.

// File: rtl/disc_pkg.sv
package disc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLAIM = 3'd1,
    ST_DATA  = 3'd2,
    ST_HOLD  = 3'd3,
    ST_REL   = 3'd4
  } disc_st_e;

  typedef struct packed {
    logic devsel_n;
    logic trdy_n;
    logic stop_n;
    logic oe;
  } strobe_t;

  localparam strobe_t STROBE_OFF = '{devsel_n: 1'b1, trdy_n: 1'b1, stop_n: 1'b1, oe: 1'b0};
endpackage

// File: rtl/disc_phase.sv
module disc_phase (
  input  logic irdy_ni,
  input  logic trdy_ni,
  input  logic stop_ni,
  output logic done_o,
  output logic xfer_o
);
  // a phase ends on irdy with either target response; data moves only with trdy
  assign done_o = ~irdy_ni & (~trdy_ni | ~stop_ni);
  assign xfer_o = ~irdy_ni & ~trdy_ni;
endmodule

// File: rtl/disc_fsm.sv
module disc_fsm
  import disc_pkg::*;
#(
  parameter int CLAIM_CYC = 1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     frame_ni,
  input  logic     hit_i,
  input  logic     stop_req_i,
  input  logic     done_i,
  output disc_st_e st_o,
  output logic     arm_o
);
  localparam int CW = (CLAIM_CYC > 1) ? $clog2(CLAIM_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(CLAIM_CYC - 1);

  disc_st_e      st_q, st_d;
  logic          arm_q, arm_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    arm_d = arm_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        arm_d = 1'b0;
        cnt_d = '0;
        if (!frame_ni && hit_i) st_d = ST_CLAIM;
      end
      ST_CLAIM: begin
        if (stop_req_i) arm_d = 1'b1;
        if (cnt_q == CNT_LAST) st_d = ST_DATA;
        else                   cnt_d = cnt_q + 1'b1;
      end
      ST_DATA: begin
        if (stop_req_i) arm_d = 1'b1;
        // phase outcome uses the stop level shown this cycle (arm_q)
        if (done_i) begin
          if (frame_ni)   st_d = ST_REL;
          else if (arm_q) st_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (frame_ni) st_d = ST_REL;
      end
      ST_REL: begin
        st_d  = ST_IDLE;
        arm_d = 1'b0;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      arm_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      arm_q <= arm_d;
      cnt_q <= cnt_d;
    end
  end

  assign st_o  = st_q;
  assign arm_o = arm_q;

  // R2
  claim_enters_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CLAIM && cnt_q == CNT_LAST) |=> st_q == ST_DATA);
  // R6
  release_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_REL |=> st_q == ST_IDLE);
endmodule

// File: rtl/disc_drv.sv
module disc_drv
  import disc_pkg::*;
(
  input  disc_st_e st_i,
  input  logic     arm_i,
  output strobe_t  drv_o
);
  always_comb begin
    drv_o = STROBE_OFF;
    unique case (st_i)
      ST_CLAIM: begin
        drv_o.devsel_n = 1'b0;
        drv_o.oe       = 1'b1;
      end
      ST_DATA: begin
        drv_o.devsel_n = 1'b0;
        drv_o.trdy_n   = 1'b0;
        drv_o.stop_n   = ~arm_i;
        drv_o.oe       = 1'b1;
      end
      ST_HOLD: begin
        drv_o.devsel_n = 1'b0;
        drv_o.stop_n   = 1'b0;
        drv_o.oe       = 1'b1;
      end
      ST_REL:  drv_o.oe = 1'b1;
      default: drv_o = STROBE_OFF;
    endcase
  end
endmodule

// File: rtl/disc_ctrl.sv
module disc_ctrl
  import disc_pkg::*;
#(
  parameter int CLAIM_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_ni,
  input  logic irdy_ni,
  input  logic hit_i,
  input  logic stop_req_i,
  output logic devsel_no,
  output logic trdy_no,
  output logic stop_no,
  output logic oe_o,
  output logic xfer_o
);
  disc_st_e st;
  logic     arm;
  logic     done;
  strobe_t  drv;

  disc_fsm #(.CLAIM_CYC(CLAIM_CYC)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frame_ni  (frame_ni),
    .hit_i     (hit_i),
    .stop_req_i(stop_req_i),
    .done_i    (done),
    .st_o      (st),
    .arm_o     (arm)
  );

  disc_drv u_drv (
    .st_i (st),
    .arm_i(arm),
    .drv_o(drv)
  );

  disc_phase u_phase (
    .irdy_ni(irdy_ni),
    .trdy_ni(drv.trdy_n),
    .stop_ni(drv.stop_n),
    .done_o (done),
    .xfer_o (xfer_o)
  );

  assign devsel_no = drv.devsel_n;
  assign trdy_no   = drv.trdy_n;
  assign stop_no   = drv.stop_n;
  assign oe_o      = drv.oe;

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (devsel_no && trdy_no && stop_no));
  // R3
  trdy_waits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trdy_no && irdy_ni) |=> !trdy_no);
  // R5
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_no && !frame_ni && (trdy_no || !irdy_ni)) |=> (!stop_no && !devsel_no && trdy_no));
  // R6
  hold_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_no && trdy_no && frame_ni) |=> (stop_no && devsel_no && trdy_no && oe_o));
  // R7
  last_phase_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trdy_no && !irdy_ni && frame_ni) |=> (trdy_no && devsel_no && stop_no));
  // R9
  no_early_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_no && trdy_no && !frame_ni) |=> !devsel_no);
endmodule

// File: tb/sim_disc_ctrl.sv
module sim_disc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CLAIM_CYC  = 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic frame_ni = 1'b1, irdy_ni = 1'b1, hit_i = 1'b0, stop_req_i = 1'b0;
  logic devsel_no, trdy_no, stop_no, oe_o, xfer_o;

  int checks = 0;
  int errors = 0;

  // model: 0 idle, 1 claim, 2 data, 3 hold, 4 release
  int m_st  = 0;
  int m_cnt = 0;
  bit m_arm = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disc_ctrl #(.CLAIM_CYC(CLAIM_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .frame_ni(frame_ni), .irdy_ni(irdy_ni),
    .hit_i(hit_i), .stop_req_i(stop_req_i), .devsel_no(devsel_no),
    .trdy_no(trdy_no), .stop_no(stop_no), .oe_o(oe_o), .xfer_o(xfer_o)
  );

  function automatic logic [3:0] exp_drv(int st, bit arm);
    case (st)
      1:       return 4'b0111;            // devsel, trdy, stop, oe
      2:       return {2'b00, ~arm, 1'b1};
      3:       return 4'b0101;
      4:       return 4'b1111;
      default: return 4'b1110;
    endcase
  endfunction

  function automatic string tag(int st);
    case (st)
      1:       return "R2";
      2:       return "R3/R4";
      3:       return "R5";
      4:       return "R6/R7/R8";
      default: return "R1/R10";
    endcase
  endfunction

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic cyc(input bit f, input bit ir, input bit h, input bit rq, input string req = "");
    bit old;
    @(negedge clk);
    frame_ni = f; irdy_ni = ir; hit_i = h; stop_req_i = rq;
    #1;
    chk(req == "" ? tag(m_st) : req, {devsel_no, trdy_no, stop_no, oe_o, xfer_o},
        {exp_drv(m_st, m_arm), (m_st == 2) && !ir});
    if (m_st == 3 && !f) chk("R9", {3'b000, devsel_no, stop_no}, 5'b0);
    @(posedge clk);
    case (m_st)
      0: if (!f && h) begin m_st = 1; m_cnt = 0; m_arm = 0; end
      1: begin
        if (rq) m_arm = 1;
        if (m_cnt == CLAIM_CYC - 1) m_st = 2; else m_cnt++;
      end
      2: begin
        old = m_arm;
        if (rq) m_arm = 1;
        if (!ir) begin
          if (f) m_st = 4; else if (old) m_st = 3;
        end
      end
      3: if (f) m_st = 4;
      default: begin m_st = 0; m_arm = 0; end
    endcase
  endtask

  task automatic disc_run(input int waits);
    cyc(0, 1, 1, 0);
    cyc(0, 1, 0, 0, "R2");
    cyc(0, 0, 0, 1, "R3");          // request while irdy asserted: phase moves data
    cyc(0, 0, 0, 0, "R4");          // stop with trdy, data moves, enter hold
    for (int i = 0; i < waits; i++) cyc(0, 1, 0, 0, "R5");
    cyc(1, 0, 0, 0, "R5");
    cyc(1, 1, 0, 0, "R6");
    cyc(1, 1, 0, 0, "R6");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    bit f, ir, h, rq, mf;
    int hw;
    void'($urandom(32'd4711));
    #(CLK_PERIOD * 2 + 2);
    // R1 during reset
    chk("R1", {devsel_no, trdy_no, stop_no, oe_o, xfer_o}, 5'b11100);
    @(negedge clk);
    rst_ni = 1'b1;
    cyc(1, 1, 1, 0, "R10");
    cyc(0, 1, 0, 0, "R10");          // no hit: no claim
    cyc(1, 1, 0, 0, "R10");
    // normal burst ending with last phase
    cyc(0, 1, 1, 0);
    cyc(0, 1, 0, 0, "R2");
    cyc(0, 0, 0, 0, "R3");
    cyc(0, 1, 0, 0, "R3");
    cyc(1, 0, 0, 0, "R7");
    cyc(1, 1, 0, 0, "R7");
    cyc(1, 1, 0, 0, "R7");
    // disconnects with 0, 1 and 5 master wait states
    disc_run(0);
    disc_run(1);
    disc_run(5);
    // disconnect coincides with the last data phase
    cyc(0, 1, 1, 0);
    cyc(0, 1, 0, 0, "R2");
    cyc(0, 1, 0, 1, "R4");
    cyc(1, 0, 0, 0, "R8");
    cyc(1, 1, 0, 0, "R8");
    cyc(1, 1, 0, 0, "R8");
    // random master
    mf = 0; hw = 0;
    for (int n = 0; n < 4000; n++) begin
      rq = ($urandom_range(0, 7) == 0);
      h  = ($urandom_range(0, 3) != 0);
      if (m_st == 0 || m_st == 4) begin
        mf = 0;
        f  = ($urandom_range(0, 2) != 0);
        ir = 1;
      end else if (mf) begin
        f = 1; ir = 0;
      end else if (m_st == 3) begin
        if (hw > 0) begin f = 0; ir = 1; hw--; end
        else begin f = 1; ir = 0; mf = 1; end
      end else begin
        f  = 0;
        ir = ($urandom_range(0, 2) == 0);
        hw = $urandom_range(0, 5);
        if (!ir && $urandom_range(0, 5) == 0) begin f = 1; mf = 1; end
      end
      cyc(f, ir, h, rq);
    end
    report();
  end
endmodule